// File: doc/BRIEF.md
# Display RAM Address Counter

This block holds the 7-bit address used to reach either the character display memory or the glyph pattern memory of a character display controller. A command decoder loads it with an address and selects which of the two spaces that address belongs to. After each data transfer the counter is stepped by one, up or down as the entry direction asks.

In the display space the address follows the wrap rules of the current line mode. One-line mode uses a single 80-location line. Two-line mode uses two 40-location lines that are not next to each other in the address map. In the glyph space the counter is a plain 6-bit counter.

Top module: `disp_addr_ctr`

## Requirements
- R1: After reset, `addr` is 0x00 and the counter is in the display space.
- R2: A display load (`ld`=1, `ld_glyph`=0) with an in-range value sets `addr` to that value on the next cycle and selects the display space.
- R3: A glyph load (`ld`=1, `ld_glyph`=1) sets `addr` to {0, `ld_addr[5:0]`} on the next cycle and selects the glyph space. Bit 6 of the value is ignored.
- R4: When `ld` and `step` are both high in one cycle, the load wins and the step has no effect.
- R5: Each cycle with `step`=1 and `ld`=0 moves `addr` by one. It moves up when `step_dn`=0 and down when `step_dn`=1. With neither strobe, `addr` holds.
- R6: In the display space with `two_line`=0, valid addresses are 0x00–0x4F. Stepping up from 0x4F gives 0x00, and stepping down from 0x00 gives 0x4F.
- R7: In the display space with `two_line`=1, valid addresses are 0x00–0x27 and 0x40–0x67. Stepping up from 0x27 gives 0x40, and stepping up from 0x67 gives 0x00.
- R8: In the display space with `two_line`=1, stepping down from 0x40 gives 0x27, and stepping down from 0x00 gives 0x67.
- R9: In the glyph space, stepping wraps modulo 64 in both directions (0x3F up to 0x00, 0x00 down to 0x3F), whatever `two_line` is.
- R10: A display load of an out-of-range value is clamped to the start of the line that follows the value's gap. With `two_line`=0, 0x50–0x7F loads as 0x00. With `two_line`=1, 0x28–0x3F loads as 0x40 and 0x68–0x7F loads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld | input | 1 | Load strobe |
| ld_glyph | input | 1 | Space select for a load: 1 = glyph, 0 = display |
| ld_addr | input | 7 | Address value to load |
| step | input | 1 | Step strobe after a data read or write |
| step_dn | input | 1 | Step direction: 1 = decrement, 0 = increment |
| two_line | input | 1 | Line mode: 1 = two lines, 0 = one line |
| addr | output | 7 | Current address |

## Verification
The bench steps across each seam of the address map. These are 0x27/0x40 and 0x67/0x00 in two-line mode, 0x4F/0x00 in one-line mode, and 0x3F/0x00 in the glyph space. A design that counted in plain binary would land in the gap at 0x28, or at 0x68 or 0x50. It also loads values into each gap. A design without clamping would then sit on an address that maps to nothing. The bench moves from the glyph space back to the display space. A stale space flag would let 0x27 step to 0x28 there. It also raises load and step together, where a wrong priority would show up as an address off by one.

// File: rtl/disp_addr_ctr.sv
module disp_addr_ctr #(
  parameter int AW = 7,
  parameter int GW = 6,
  parameter logic [AW-1:0] ONE_END = 7'h4F,
  parameter logic [AW-1:0] L1_END  = 7'h27,
  parameter logic [AW-1:0] L2_BEG  = 7'h40,
  parameter logic [AW-1:0] L2_END  = 7'h67
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          ld_glyph,
  input  logic [AW-1:0] ld_addr,
  input  logic          step,
  input  logic          step_dn,
  input  logic          two_line,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] ZERO = '0;
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [GW-1:0] GONE = GW'(1);

  logic          glyph_q;
  logic [AW-1:0] ld_val, up_val, dn_val, step_val;
  logic [GW-1:0] g_cur;

  assign g_cur = addr[GW-1:0];

  always_comb begin
    if (ld_glyph)
      ld_val = {{(AW-GW){1'b0}}, ld_addr[GW-1:0]};
    else if (!two_line)
      ld_val = (ld_addr > ONE_END) ? ZERO : ld_addr;
    else if (ld_addr > L2_END)
      ld_val = ZERO;
    else if (ld_addr > L1_END && ld_addr < L2_BEG)
      ld_val = L2_BEG;
    else
      ld_val = ld_addr;
  end

  always_comb begin
    if (!two_line) begin
      up_val = (addr >= ONE_END) ? ZERO : addr + ONE;
      dn_val = (addr == ZERO) ? ONE_END : addr - ONE;
    end else begin
      up_val = (addr == L1_END) ? L2_BEG :
               (addr >= L2_END) ? ZERO : addr + ONE;
      dn_val = (addr == L2_BEG) ? L1_END :
               (addr == ZERO)   ? L2_END : addr - ONE;
    end
  end

  assign step_val = glyph_q ? {{(AW-GW){1'b0}}, (step_dn ? g_cur - GONE : g_cur + GONE)}
                            : (step_dn ? dn_val : up_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= ZERO;
      glyph_q <= 1'b0;
    end else if (ld) begin
      addr    <= ld_val;
      glyph_q <= ld_glyph;
    end else if (step) begin
      addr    <= step_val;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !step) |=> $stable(addr));

  assert_glyph_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ld_glyph) |=> addr == {1'b0, $past(ld_addr[5:0])});

  assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ld_glyph && !two_line && ld_addr <= 7'h4F) |=> addr == $past(ld_addr));

  assert_seam_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && !step_dn && two_line && !glyph_q && addr == 7'h27) |=> addr == 7'h40);

  assert_seam_dn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && step_dn && two_line && !glyph_q && addr == 7'h40) |=> addr == 7'h27);

  assert_glyph_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    glyph_q |-> addr[6] == 1'b0);

endmodule

// File: tb/sim_disp_addr_ctr.sv
`timescale 1ns/1ps
module sim_disp_addr_ctr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld = 0, ld_glyph = 0, step = 0, step_dn = 0, two_line = 0;
  logic [6:0] ld_addr = '0;
  logic [6:0] addr;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  disp_addr_ctr u0 (.clk(clk), .rst_n(rst_n), .ld(ld), .ld_glyph(ld_glyph),
    .ld_addr(ld_addr), .step(step), .step_dn(step_dn), .two_line(two_line), .addr(addr));

  // {req[3:0], ld, glyph, val[6:0], step, dn, two, exp[6:0]}
  localparam int NV = 32;
  localparam logic [22:0] VEC [NV] = '{
    {4'd2,  1'b1,1'b0,7'h26,1'b0,1'b0,1'b1,7'h26}, // R2
    {4'd5,  1'b0,1'b0,7'h00,1'b1,1'b0,1'b1,7'h27}, // R5
    {4'd7,  1'b0,1'b0,7'h00,1'b1,1'b0,1'b1,7'h40}, // R7
    {4'd8,  1'b0,1'b0,7'h00,1'b1,1'b1,1'b1,7'h27}, // R8
    {4'd7,  1'b0,1'b0,7'h00,1'b1,1'b0,1'b1,7'h40}, // R7
    {4'd8,  1'b0,1'b0,7'h00,1'b1,1'b1,1'b1,7'h27}, // R8 back again
    {4'd2,  1'b1,1'b0,7'h66,1'b0,1'b0,1'b1,7'h66}, // R2
    {4'd5,  1'b0,1'b0,7'h00,1'b1,1'b0,1'b1,7'h67}, // R5
    {4'd7,  1'b0,1'b0,7'h00,1'b1,1'b0,1'b1,7'h00}, // R7
    {4'd8,  1'b0,1'b0,7'h00,1'b1,1'b1,1'b1,7'h67}, // R8
    {4'd5,  1'b0,1'b0,7'h00,1'b0,1'b0,1'b1,7'h67}, // R5 hold
    {4'd2,  1'b1,1'b0,7'h4E,1'b0,1'b0,1'b0,7'h4E}, // R2
    {4'd6,  1'b0,1'b0,7'h00,1'b1,1'b0,1'b0,7'h4F}, // R6
    {4'd6,  1'b0,1'b0,7'h00,1'b1,1'b0,1'b0,7'h00}, // R6
    {4'd6,  1'b0,1'b0,7'h00,1'b1,1'b1,1'b0,7'h4F}, // R6
    {4'd4,  1'b1,1'b0,7'h10,1'b1,1'b0,1'b0,7'h10}, // R4
    {4'd5,  1'b0,1'b0,7'h00,1'b1,1'b1,1'b0,7'h0F}, // R5 down
    {4'd4,  1'b1,1'b0,7'h20,1'b1,1'b1,1'b1,7'h20}, // R4
    {4'd3,  1'b1,1'b1,7'h7F,1'b0,1'b0,1'b1,7'h3F}, // R3
    {4'd9,  1'b0,1'b0,7'h00,1'b1,1'b0,1'b1,7'h00}, // R9
    {4'd9,  1'b0,1'b0,7'h00,1'b1,1'b1,1'b0,7'h3F}, // R9
    {4'd3,  1'b1,1'b1,7'h27,1'b0,1'b0,1'b1,7'h27}, // R3
    {4'd9,  1'b0,1'b0,7'h00,1'b1,1'b0,1'b1,7'h28}, // R9
    {4'd3,  1'b1,1'b1,7'h4F,1'b0,1'b0,1'b0,7'h0F}, // R3
    {4'd9,  1'b0,1'b0,7'h00,1'b1,1'b0,1'b0,7'h10}, // R9
    {4'd2,  1'b1,1'b0,7'h27,1'b0,1'b0,1'b1,7'h27}, // R2
    {4'd7,  1'b0,1'b0,7'h00,1'b1,1'b0,1'b1,7'h40}, // R7 after leaving glyph space
    {4'd10, 1'b1,1'b0,7'h30,1'b0,1'b0,1'b1,7'h40}, // R10
    {4'd10, 1'b1,1'b0,7'h55,1'b0,1'b0,1'b0,7'h00}, // R10
    {4'd10, 1'b1,1'b0,7'h45,1'b0,1'b0,1'b1,7'h45}, // R10
    {4'd10, 1'b1,1'b0,7'h70,1'b0,1'b0,1'b1,7'h00}, // R10
    {4'd10, 1'b1,1'b0,7'h28,1'b0,1'b0,1'b1,7'h40}  // R10
  };

  task automatic check(input int req, input logic [6:0] exp);
    n_chk++;
    if (addr !== exp) begin
      n_bad++;
      $display("FAIL R%0d addr=%h expected=%h", req, addr, exp);
    end
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(1, 7'h00); // R1
    @(negedge clk) rst_n = 1'b1;
    two_line = 1'b0; step = 1'b1; step_dn = 1'b1;
    @(posedge clk); #1 check(6, 7'h4F); // R6 down from reset value: confirms display space
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ld, ld_glyph, ld_addr, step, step_dn, two_line} = VEC[i][18:7];
      @(posedge clk); #1 check(int'(VEC[i][22:19]), VEC[i][6:0]);
    end
    @(negedge clk) {ld, ld_glyph, ld_addr, step} = {1'b1, 1'b1, 7'h05, 1'b0};
    @(posedge clk);
    @(negedge clk) begin rst_n = 1'b0; ld = 1'b0; end
    @(posedge clk); #1 check(1, 7'h00); // R1 mid-run reset
    @(negedge clk) begin rst_n = 1'b1; two_line = 1'b1; step = 1'b1; step_dn = 1'b1; end
    @(posedge clk); #1 check(1, 7'h67); // R1 reset returns display space (R8 rule)
    @(negedge clk) step = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule